// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block sits between a register write port and the command side of a card interface. Software loads a 32-bit argument and then a 16-bit command word. If bit 15 (start) of that word is set, the block sends the 6-bit index from bits 5:0 and the argument to the card-side port with a one-cycle start pulse. It then waits for the port's done pulse, which brings a response length, an error flag and up to sixteen response bytes.

When done arrives, the block checks the returned length against the flags in the command word. It packs an accepted response into four 32-bit response words. Any failure is recorded in two places: a sticky fail bit in the command word and a command-timeout bit in a status word. A busy-wait command that completes without error can raise a busy status bit when the busy enable is set in the configuration. The command and argument registers ignore writes from the start pulse until the command has been committed, so the request cannot change while it is outstanding.

The sequencer has four states. IDLE accepts register writes, and a start-flagged command write (launch) moves it to ISSUE. ISSUE drives the start pulse for one cycle and always moves to WAIT. WAIT stays in place until done, capturing the port outputs on the done cycle and moving to COMMIT. COMMIT applies the result to the command, status and response registers and returns to IDLE.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset, the command word, the argument, all four response words and the status word read zero, busy is low and no start pulse is driven.
- R2: A command write (select 0) with bit 15 set while idle drives cp_start high for exactly one cycle in the next cycle, with cp_index equal to bits 5:0 and cp_arg equal to the argument. Bit 15 reads back clear once the command is committed. A command write with bit 15 clear is only stored and produces no start pulse.
- R3: From the start pulse until the command is committed, writes to the command word (select 0) and to the argument (select 1) have no effect.
- R4: A 4-byte response to a command without the long flag (bit 9) is accepted. Response word 0 takes bytes 0..3 big-endian, so byte 0 lands in its bits 31:24, and words 1..3 become zero. Byte k of cp_data is cp_data[127-8k -: 8].
- R5: A 16-byte response is accepted whether or not the long flag is set. Word 0 takes bytes 12..15, word 1 takes bytes 8..11, word 2 takes bytes 4..7 and word 3 takes bytes 0..3, each big-endian.
- R6: When a response is expected (bit 10 clear), each of the following is an error: length 0, length 4 with the long flag set, or any length other than 4 or 16. An error sets fail bit 14 of the command word and timeout bit 6 of the status word, and leaves the response words unchanged.
- R7: An asserted cp_err is an error even when bit 10 (no response) is set.
- R8: With bit 10 set and no cp_err, the length is not checked, the response words are unchanged and no fail is reported.
- R9: A busy-wait command (bit 11) that completes without error sets status bit 10 only when configuration bit 10 (written with select 2) is set. A failed busy-wait command does not set it.
- R10: A status write (select 3) clears each status bit that has a 1 in the written data.
- R11: An accepted command write replaces the whole command word, so writing a new command with bit 14 clear removes an earlier fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 argument, 2 configuration, 3 status clear |
| wr_data | input | 32 | Register write data |
| cmd_word | output | 16 | Command word (start, fail, flags, index) |
| arg_word | output | 32 | Argument register |
| status_word | output | 16 | Status: bit 6 timeout, bit 10 busy |
| rsp_flat | output | 128 | Response words, word k at bits 32k+31:32k |
| busy | output | 1 | A command is in flight |
| cp_start | output | 1 | One-cycle request strobe to the card port |
| cp_index | output | 6 | Command index sent with the request |
| cp_arg | output | 32 | Argument sent with the request |
| cp_done | input | 1 | Card port completion strobe |
| cp_err | input | 1 | Card port error, valid with cp_done |
| cp_len | input | 5 | Response length in bytes, valid with cp_done |
| cp_data | input | 128 | Response bytes, byte 0 in bits 127:120 |

## Verification
A sequencer stuck in or skipping a state shows up at the ports within one cycle. The start pulse is missing or longer than one cycle, busy fails to return low, or bit 15 stays set two cycles after done. A wrong check or packing decision becomes visible in the cycle after COMMIT, as a wrong fail bit, a wrong timeout bit or a wrong response word. A broken write lockout only appears after completion, as a command or argument word that differs from the one issued.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int CMD_W     = 16;
    localparam int IDX_W     = 6;
    localparam int B_NEW     = 15;
    localparam int B_FAIL    = 14;
    localparam int B_BUSYW   = 11;
    localparam int B_NORSP   = 10;
    localparam int B_LONG    = 9;
    localparam int ST_TMO    = 6;
    localparam int ST_BUSY   = 10;
    localparam int CFG_BUSYE = 10;

    typedef enum logic [1:0] {
        SEL_CMD = 2'd0,
        SEL_ARG = 2'd1,
        SEL_CFG = 2'd2,
        SEL_STS = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_COMMIT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sdc_seq.sv
module sdc_seq
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       cp_done,
    output seq_state_e state_o,
    output logic       cp_start,
    output logic       cap_en,
    output logic       commit,
    output logic       busy
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (cp_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cp_start = 1'b0;
        cap_en   = 1'b0;
        commit   = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy     = 1'b0;
            ST_ISSUE:  cp_start = 1'b1;
            ST_WAIT:   cap_en   = cp_done;
            ST_COMMIT: commit   = 1'b1;
        endcase
    end

    assign state_o = state_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_start |=> !cp_start); // R2
    AST_LAUNCH_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && launch) |=> cp_start); // R2
endmodule

// File: rtl/sdc_rsp_eval.sv
module sdc_rsp_eval #(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    localparam int DATA_W      = WORD_W * RSP_WORDS,
    localparam int LONG_BYTES  = DATA_W / 8,
    localparam int SHORT_BYTES = WORD_W / 8,
    localparam int LEN_W       = $clog2(LONG_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LEN_W-1:0]  cp_len,
    input  logic              cp_err,
    input  logic [DATA_W-1:0] cp_data,
    input  logic              no_rsp,
    input  logic              long_rsp,
    output logic              fail,
    output logic              load_rsp,
    output logic [DATA_W-1:0] rsp_next
);
    logic [LEN_W-1:0]  cap_len;
    logic              cap_err;
    logic [DATA_W-1:0] cap_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_len  <= '0;
            cap_err  <= 1'b0;
            cap_data <= '0;
        end else if (cap_en) begin
            cap_len  <= cp_len;
            cap_err  <= cp_err;
            cap_data <= cp_data;
        end
    end

    logic is_short, is_long, len_bad;
    assign is_short = (cap_len == LEN_W'(SHORT_BYTES));
    assign is_long  = (cap_len == LEN_W'(LONG_BYTES));
    assign len_bad  = (cap_len == '0) || (is_short && long_rsp) || !(is_short || is_long);
    assign fail     = cap_err || (!no_rsp && len_bad);
    assign load_rsp = !fail && !no_rsp;

    for (genvar g = 0; g < RSP_WORDS; g++) begin : g_word
        if (g == 0) begin : g_first
            assign rsp_next[g*WORD_W +: WORD_W] = is_short ? cap_data[DATA_W-1 -: WORD_W]
                                                           : cap_data[g*WORD_W +: WORD_W];
        end else begin : g_rest
            assign rsp_next[g*WORD_W +: WORD_W] = is_short ? '0
                                                           : cap_data[g*WORD_W +: WORD_W];
        end
    end

    AST_ERR_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_err |-> (fail && !load_rsp)); // R7
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    localparam int DATA_W = WORD_W * RSP_WORDS,
    localparam int LEN_W  = $clog2(DATA_W / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ARG_W-1:0]  wr_data,
    output logic [CMD_W-1:0]  cmd_word,
    output logic [ARG_W-1:0]  arg_word,
    output logic [15:0]       status_word,
    output logic [DATA_W-1:0] rsp_flat,
    output logic              busy,
    output logic              cp_start,
    output logic [IDX_W-1:0]  cp_index,
    output logic [ARG_W-1:0]  cp_arg,
    input  logic              cp_done,
    input  logic              cp_err,
    input  logic [LEN_W-1:0]  cp_len,
    input  logic [DATA_W-1:0] cp_data
);
    logic [CMD_W-1:0]  cmd_q;
    logic [ARG_W-1:0]  arg_q;
    logic [DATA_W-1:0] rsp_q, rsp_next;
    logic              cfg_busy_ie, sts_tmo, sts_busy;
    logic              launch, cap_en, commit, fail, load_rsp;
    seq_state_e        state;
    reg_sel_e          sel;

    assign sel    = reg_sel_e'(wr_sel);
    assign launch = wr_en && (sel == SEL_CMD) && wr_data[B_NEW];

    sdc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .cp_done  (cp_done),
        .state_o  (state),
        .cp_start (cp_start),
        .cap_en   (cap_en),
        .commit   (commit),
        .busy     (busy)
    );

    sdc_rsp_eval #(.WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cp_len   (cp_len),
        .cp_err   (cp_err),
        .cp_data  (cp_data),
        .no_rsp   (cmd_q[B_NORSP]),
        .long_rsp (cmd_q[B_LONG]),
        .fail     (fail),
        .load_rsp (load_rsp),
        .rsp_next (rsp_next)
    );

    logic idle;
    assign idle = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            arg_q       <= '0;
            rsp_q       <= '0;
            cfg_busy_ie <= 1'b0;
            sts_tmo     <= 1'b0;
            sts_busy    <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (sel)
                    SEL_CMD: if (idle) cmd_q <= wr_data[CMD_W-1:0];
                    SEL_ARG: if (idle) arg_q <= wr_data;
                    SEL_CFG: cfg_busy_ie <= wr_data[CFG_BUSYE];
                    SEL_STS: begin
                        if (wr_data[ST_TMO])  sts_tmo  <= 1'b0;
                        if (wr_data[ST_BUSY]) sts_busy <= 1'b0;
                    end
                endcase
            end
            if (commit) begin
                cmd_q[B_NEW] <= 1'b0;
                if (fail) begin
                    cmd_q[B_FAIL] <= 1'b1;
                    sts_tmo       <= 1'b1;
                end else if (cmd_q[B_BUSYW] && cfg_busy_ie) begin
                    sts_busy <= 1'b1;
                end
                if (load_rsp) rsp_q <= rsp_next;
            end
        end
    end

    always_comb begin
        status_word          = '0;
        status_word[ST_TMO]  = sts_tmo;
        status_word[ST_BUSY] = sts_busy;
    end

    assign cmd_word = cmd_q;
    assign arg_word = arg_q;
    assign rsp_flat = rsp_q;
    assign cp_index = cmd_q[IDX_W-1:0];
    assign cp_arg   = arg_q;

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(cmd_q)); // R3
    AST_ARG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arg_q)); // R3
    AST_NEW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !cmd_q[B_NEW]); // R2
    AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && fail) |=> (cmd_q[B_FAIL] && sts_tmo && $stable(rsp_q))); // R6
    AST_NORSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_q[B_NORSP]) |=> $stable(rsp_q)); // R8
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_busy) |-> ($past(cfg_busy_ie) && !$past(fail))); // R9
endmodule

// File: tb/tb_sd_cmd_issuer.sv
module tb_sd_cmd_issuer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [31:0]  wr_data = '0;
    logic [15:0]  cmd_word;
    logic [31:0]  arg_word;
    logic [15:0]  status_word;
    logic [127:0] rsp_flat;
    logic         busy, cp_start;
    logic [5:0]   cp_index;
    logic [31:0]  cp_arg;
    logic         cp_done = 1'b0;
    logic         cp_err = 1'b0;
    logic [4:0]   cp_len = '0;
    logic [127:0] cp_data = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    localparam logic [127:0] PAT_A = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] PAT_B = 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4;

    always #2 clk = ~clk;

    sd_cmd_issuer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_word(cmd_word), .arg_word(arg_word), .status_word(status_word),
        .rsp_flat(rsp_flat), .busy(busy), .cp_start(cp_start), .cp_index(cp_index),
        .cp_arg(cp_arg), .cp_done(cp_done), .cp_err(cp_err), .cp_len(cp_len),
        .cp_data(cp_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] rw(input int k);
        return rsp_flat[k*32 +: 32];
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_cmd(input logic [15:0] c, input logic [31:0] a);
        wr(2'd0, {16'h0, c});
        chk("R2", "start pulse", cp_start, 1'b1);
        chk("R2", "index", cp_index, c[5:0]);
        chk("R2", "argument", cp_arg, a);
    endtask

    task automatic finish_cmd(input logic [4:0] len, input logic err, input logic [127:0] d);
        @(negedge clk);
        chk("R2", "start pulse ended", cp_start, 1'b0);
        cp_done = 1'b1; cp_len = len; cp_err = err; cp_data = d;
        @(negedge clk);
        cp_done = 1'b0; cp_err = 1'b0;
        @(negedge clk);
        chk("R2", "busy after commit", busy, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1", "cmd", cmd_word, 16'h0);
        chk("R1", "arg", arg_word, 32'h0);
        chk("R1", "status", status_word, 16'h0);
        chk("R1", "rsp", rsp_flat, 128'h0);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "start", cp_start, 1'b0);
    endtask

    task automatic t_long;
        wr(2'd1, 32'hCAFE0001);
        start_cmd(16'h8202, 32'hCAFE0001);
        finish_cmd(5'd16, 1'b0, PAT_A);
        chk("R5", "w0", rw(0), 32'hCCDDEEFF);
        chk("R5", "w1", rw(1), 32'h8899AABB);
        chk("R5", "w2", rw(2), 32'h44556677);
        chk("R5", "w3", rw(3), 32'h00112233);
        chk("R2", "start bit cleared", cmd_word, 16'h0202);
        start_cmd(16'h8009, 32'hCAFE0001);
        finish_cmd(5'd16, 1'b0, PAT_B);
        chk("R5", "w0 no long flag", rw(0), 32'hD1D2D3D4);
        chk("R5", "w3 no long flag", rw(3), 32'hA1A2A3A4);
    endtask

    task automatic t_short;
        wr(2'd1, 32'hDEADBEEF);
        start_cmd(16'h8011, 32'hDEADBEEF);
        finish_cmd(5'd4, 1'b0, PAT_A);
        chk("R4", "w0", rw(0), 32'h00112233);
        chk("R4", "w1 zero", rw(1), 32'h0);
        chk("R4", "w2 zero", rw(2), 32'h0);
        chk("R4", "w3 zero", rw(3), 32'h0);
        chk("R2", "cmd readback", cmd_word, 16'h0011);
        chk("R4", "status clean", status_word, 16'h0);
    endtask

    task automatic t_len_err;
        logic [127:0] keep;
        keep = rsp_flat;
        start_cmd(16'h8005, 32'hDEADBEEF);
        finish_cmd(5'd0, 1'b0, PAT_B);
        chk("R6", "len0 cmd fail", cmd_word, 16'h4005);
        chk("R6", "len0 timeout", status_word, 16'h0040);
        chk("R6", "len0 rsp kept", rsp_flat, keep);
        wr(2'd3, 32'h0000_0040);
        chk("R10", "timeout cleared", status_word, 16'h0);
        start_cmd(16'h8207, 32'hDEADBEEF);
        finish_cmd(5'd4, 1'b0, PAT_B);
        chk("R6", "short on long fail", cmd_word, 16'h4207);
        chk("R6", "short on long rsp kept", rsp_flat, keep);
        start_cmd(16'h8008, 32'hDEADBEEF);
        finish_cmd(5'd8, 1'b0, PAT_B);
        chk("R6", "len8 fail", cmd_word, 16'h4008);
        chk("R6", "len8 timeout", status_word[6], 1'b1);
        start_cmd(16'h8003, 32'hDEADBEEF);
        finish_cmd(5'd4, 1'b0, PAT_B);
        chk("R11", "fail flag replaced", cmd_word, 16'h0003);
        chk("R4", "w0 after recovery", rw(0), 32'hA1A2A3A4);
        wr(2'd3, 32'h0000_FFFF);
        chk("R10", "all cleared", status_word, 16'h0);
    endtask

    task automatic t_noresp;
        logic [127:0] keep;
        keep = rsp_flat;
        start_cmd(16'h8400, 32'hDEADBEEF);
        finish_cmd(5'd0, 1'b0, PAT_A);
        chk("R8", "no fail", cmd_word, 16'h0400);
        chk("R8", "rsp kept", rsp_flat, keep);
        chk("R8", "status", status_word, 16'h0);
        start_cmd(16'h8401, 32'hDEADBEEF);
        finish_cmd(5'd16, 1'b0, PAT_A);
        chk("R8", "rsp kept len16", rsp_flat, keep);
        start_cmd(16'h8402, 32'hDEADBEEF);
        finish_cmd(5'd0, 1'b1, PAT_A);
        chk("R7", "error fails", cmd_word, 16'h4402);
        chk("R7", "error timeout", status_word, 16'h0040);
        wr(2'd3, 32'h0000_0040);
    endtask

    task automatic t_busy;
        wr(2'd2, 32'h0);
        start_cmd(16'h8807, 32'hDEADBEEF);
        finish_cmd(5'd4, 1'b0, PAT_A);
        chk("R9", "disabled no busy", status_word, 16'h0);
        wr(2'd2, 32'h0000_0400);
        start_cmd(16'h8807, 32'hDEADBEEF);
        finish_cmd(5'd4, 1'b0, PAT_A);
        chk("R9", "enabled busy", status_word, 16'h0400);
        wr(2'd3, 32'h0000_0400);
        chk("R10", "busy cleared", status_word, 16'h0);
        start_cmd(16'h8807, 32'hDEADBEEF);
        finish_cmd(5'd0, 1'b0, PAT_A);
        chk("R9", "failed busywait", status_word, 16'h0040);
        wr(2'd3, 32'h0000_0040);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_lock;
        wr(2'd1, 32'h0BADF00D);
        start_cmd(16'h8012, 32'h0BADF00D);
        wr(2'd0, 32'h0000_803F);
        wr(2'd1, 32'h12345678);
        chk("R3", "no restart", cp_start, 1'b0);
        finish_cmd(5'd4, 1'b0, PAT_A);
        chk("R3", "cmd unchanged", cmd_word, 16'h0012);
        chk("R3", "arg unchanged", arg_word, 32'h0BADF00D);
        @(negedge clk);
        chk("R3", "no second start", cp_start, 1'b0);
    endtask

    task automatic t_nostart;
        wr(2'd0, 32'h0000_0013);
        chk("R2", "stored no start", cp_start, 1'b0);
        chk("R2", "stored busy low", busy, 1'b0);
        chk("R2", "stored word", cmd_word, 16'h0013);
        wr(2'd1, 32'h55AA55AA);
        chk("R2", "arg while idle", arg_word, 32'h55AA55AA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long();
        t_short();
        t_len_err();
        t_noresp();
        t_busy();
        t_lock();
        t_nostart();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule